// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Cycle Controller

This block sits between a simple request stream and an asynchronous pseudo-static RAM with a 23-bit word address and a 16-bit data path split into two byte lanes. Each accepted request is a single read or write with per-lane enables. The controller drives the memory's two chip selects (one active-low, one active-high), output enable, write enable, the active-low per-lane byte selects, the address and a split data bus with an output-enable for the host-side tri-state buffer. Every timing phase is a clock-cycle count computed from nanosecond parameters and the clock period, always rounded up.

Because the memory refreshes itself behind the host's back, the controller enforces its hidden-refresh rules. After reset the device is held deselected for a power-up window. Back-to-back writes may share one chip-select-low run to save the deselect gap. Once such a run has been open long enough, or has carried many writes, each further write pulse is widened to the longer pulse width.

Requests use valid/ready. `req_ready` is low during power-up, during an access and its recovery, and while a read response is waiting. The one exception is the last recovery cycle of a write: there `req_ready` is high when the presented request is a write, and that write continues the open run. Read responses use valid/ready. `rsp_valid` and `rsp_rdata` hold until `rsp_ready` is seen high.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset is released the chip is deselected and `req_ready` stays low for exactly PWR cycles, where PWR = ceil(200 us / clock period). `req_ready` first reads high after the PWR-th rising edge.
- R2: The memory is selected only when `ps_ce_n`=0 and `ps_ce`=1. Whenever it is not selected, `ps_we_n` and `ps_oe_n` are high and `ps_dq_oe` is low. Reset leaves the chip deselected and `rsp_valid` low.
- R3: A read keeps the chip selected with `ps_oe_n` low and `ps_we_n` high for exactly RC = ceil(70 ns / period) cycles. Byte select n is low exactly when `req_be[n]` is set, with lane 0 being bits 7:0 and lane 1 being bits 15:8. The data bus is sampled on the last of those cycles, and lanes that were not enabled read as zero.
- R4: A write has three phases. First comes one setup cycle with the chip selected, `ps_we_n` high and data driven. Then `ps_we_n` is low for WP = ceil(55 ns / period) cycles. Then `ps_we_n` is high for the recovery cycles. Only enabled lanes are written, so a read-back of a disabled lane returns its old contents.
- R5: A write keeps the chip selected for 1 + WP + max(1, ceil(70 ns / period) - 1 - WP) cycles. This is 8 cycles at the default 10 ns clock.
- R6: `ps_dq_oe` is high only in the write setup and pulse phases. It is never high while `ps_oe_n` is low, and `ps_we_n` is never low without `ps_dq_oe`.
- R7: Within one chip-select-low run, a write pulse is widened to ceil(70 ns / period) cycles in two cases. One is when its end would fall more than ceil(1.2 us / period) cycles after the run began. The other is when 50 or more writes already ran in the run.
- R8: Between two selected periods the chip is deselected for at least max(1, ceil(10 ns / period)) cycles.
- R9: A write presented on the last recovery cycle of a write is accepted in that cycle and continues the same chip-select-low run with no deselect gap.
- R10: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a read access is in progress.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_rdata` is unchanged, and no new request is accepted in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ps_ce_n | output | 1 | Active-low chip select |
| ps_ce | output | 1 | Active-high chip select |
| ps_oe_n | output | 1 | Active-low output enable |
| ps_we_n | output | 1 | Active-low write enable |
| ps_bsel_n | output | 2 | Active-low byte selects, bit 0 = low lane |
| ps_addr | output | 23 | Memory address |
| ps_dq_out | output | 16 | Data toward memory |
| ps_dq_oe | output | 1 | Host tri-state enable for ps_dq_out |
| ps_dq_in | input | 16 | Data from memory |

## Verification
The checker assumes a well-behaved request stream: once `req_valid` is raised, the payload is held stable until the request is accepted. It also assumes `ps_dq_in` is only meaningful during a read window. The pulse-width, gap and power-up properties are measured with counters in the checker, and they need no assumption about the inputs. The bench drives every request through a task that holds the payload until acceptance. Its memory model returns a filler byte on unselected lanes, so the lane masking is exposed without breaking those assumptions.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WPULSE,
    ST_WREC,
    ST_GAP
  } st_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_tcount.sv
module psram_tcount #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/psram_run_guard.sv
module psram_run_guard #(
  parameter int WPS       = 6,
  parameter int RUN_CYC   = 120,
  parameter int RUN_WR    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic wr_start,
  output logic stretch
);
  localparam int RW = $clog2(RUN_CYC + 1) + 1;
  localparam int WW = $clog2(RUN_WR + 1) + 1;

  logic [RW-1:0] run;
  logic [WW-1:0] nwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
      nwr <= '0;
    end else if (!cs_act) begin
      run <= '0;
      nwr <= '0;
    end else begin
      if (run != RW'(RUN_CYC)) run <= run + 1'b1;
      if (wr_start && nwr != WW'(RUN_WR)) nwr <= nwr + 1'b1;
    end
  end

  // pulse starts on the next cycle and lasts WPS cycles
  assign stretch = ((32'(run) + 32'(1 + WPS)) > 32'(RUN_CYC)) ||
                   (nwr == WW'(RUN_WR));
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_PS       = 10000,
  parameter int ADDR_W       = 23,
  parameter int DATA_W       = 16,
  parameter int T_PWRUP_NS   = 200000,
  parameter int T_RC_NS      = 70,
  parameter int T_AA_NS      = 70,
  parameter int T_WC_NS      = 70,
  parameter int T_WP_NS      = 55,
  parameter int T_WP_LONG_NS = 70,
  parameter int T_DW_NS      = 30,
  parameter int T_CSH_NS     = 10,
  parameter int T_RUN_NS     = 1200,
  parameter int RUN_WRITES   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ps_ce_n,
  output logic              ps_ce,
  output logic              ps_oe_n,
  output logic              ps_we_n,
  output logic [DATA_W/8-1:0] ps_bsel_n,
  output logic [ADDR_W-1:0] ps_addr,
  output logic [DATA_W-1:0] ps_dq_out,
  output logic              ps_dq_oe,
  input  logic [DATA_W-1:0] ps_dq_in
);
  localparam int LANES   = DATA_W / 8;
  localparam int PWR_CYC = max2(1, ns2cyc(T_PWRUP_NS, CLK_PS));
  localparam int RC_CYC  = max2(1, max2(ns2cyc(T_RC_NS, CLK_PS), ns2cyc(T_AA_NS, CLK_PS)));
  // data is driven from the setup cycle, so setup + pulse must cover data setup
  localparam int WPS_CYC = max2(max2(1, ns2cyc(T_WP_NS, CLK_PS)), ns2cyc(T_DW_NS, CLK_PS) - 1);
  localparam int WPL_CYC = max2(WPS_CYC, ns2cyc(T_WP_LONG_NS, CLK_PS));
  localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_PS);
  localparam int WRC_CYC = max2(1, WC_CYC - 1 - WPS_CYC);
  localparam int CSH_CYC = max2(1, ns2cyc(T_CSH_NS, CLK_PS));
  localparam int RUN_CYC = max2(WPL_CYC + 2, ns2cyc(T_RUN_NS, CLK_PS));
  localparam int TW      = $clog2(PWR_CYC + RC_CYC + WPL_CYC + 2);

  st_e state, state_nx;

  logic              t_load, t_last, stretch, accept, cs_act;
  logic [TW-1:0]     t_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_mask;
  logic [LANES-1:0]  be_q;

  assign cs_act = (state == ST_READ) || (state == ST_WSET) ||
                  (state == ST_WPULSE) || (state == ST_WREC);

  assign req_ready = ((state == ST_IDLE) && !rsp_valid) ||
                     ((state == ST_WREC) && t_last && req_write);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nx = state;
    t_load   = 1'b0;
    t_val    = '0;
    unique case (state)
      ST_PWRUP:  if (t_last) state_nx = ST_IDLE;
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_nx = ST_WSET;
          end else begin
            state_nx = ST_READ;
            t_load   = 1'b1;
            t_val    = TW'(RC_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (t_last) begin
          state_nx = ST_GAP;
          t_load   = 1'b1;
          t_val    = TW'(CSH_CYC - 1);
        end
      end
      ST_WSET: begin
        state_nx = ST_WPULSE;
        t_load   = 1'b1;
        t_val    = stretch ? TW'(WPL_CYC - 1) : TW'(WPS_CYC - 1);
      end
      ST_WPULSE: begin
        if (t_last) begin
          state_nx = ST_WREC;
          t_load   = 1'b1;
          t_val    = TW'(WRC_CYC - 1);
        end
      end
      ST_WREC: begin
        if (t_last) begin
          if (accept) begin
            state_nx = ST_WSET;
          end else begin
            state_nx = ST_GAP;
            t_load   = 1'b1;
            t_val    = TW'(CSH_CYC - 1);
          end
        end
      end
      ST_GAP:   if (t_last) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  psram_tcount #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  psram_run_guard #(.WPS(WPS_CYC), .RUN_CYC(RUN_CYC), .RUN_WR(RUN_WRITES)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .wr_start (state == ST_WSET),
    .stretch  (stretch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_PWRUP;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if ((state == ST_READ) && t_last) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= ps_dq_in & rd_mask;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_mask[g*8 +: 8] = {8{be_q[g]}};
    assign ps_bsel_n[g]      = !(cs_act && be_q[g]);
  end

  assign ps_ce_n   = !cs_act;
  assign ps_ce     = cs_act;
  assign ps_oe_n   = (state != ST_READ);
  assign ps_we_n   = (state != ST_WPULSE);
  assign ps_addr   = addr_q;
  assign ps_dq_out = wdata_q;
  assign ps_dq_oe  = (state == ST_WSET) || (state == ST_WPULSE);
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_PS     = 10000,
  parameter int DATA_W     = 16,
  parameter int T_PWRUP_NS = 200000,
  parameter int T_RC_NS    = 70,
  parameter int T_AA_NS    = 70,
  parameter int T_WP_NS    = 55,
  parameter int T_CSH_NS   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              ps_ce_n,
  input logic              ps_ce,
  input logic              ps_oe_n,
  input logic              ps_we_n,
  input logic              ps_dq_oe
);
  localparam int PWR = max2(1, ns2cyc(T_PWRUP_NS, CLK_PS));
  localparam int RC  = max2(1, max2(ns2cyc(T_RC_NS, CLK_PS), ns2cyc(T_AA_NS, CLK_PS)));
  localparam int WP  = max2(1, ns2cyc(T_WP_NS, CLK_PS));
  localparam int CSH = max2(1, ns2cyc(T_CSH_NS, CLK_PS));

  logic        sel;
  logic [31:0] up_cnt, wl_cnt, lo_cnt, hi_cnt;

  assign sel = !ps_ce_n && ps_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
      wl_cnt <= '0;
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (up_cnt != 32'hFFFF_FFFF) up_cnt <= up_cnt + 1;
      wl_cnt <= ps_we_n ? '0 : wl_cnt + 1;
      lo_cnt <= sel ? lo_cnt + 1 : '0;
      hi_cnt <= sel ? '0 : ((hi_cnt != 32'hFFFF_FFFF) ? hi_cnt + 1 : hi_cnt);
    end
  end

  a_r1_pwrup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (up_cnt >= 32'(PWR)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (ps_we_n && ps_oe_n && !ps_dq_oe));

  a_r3_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ps_ce_n) && !$past(ps_oe_n)) |-> (lo_cnt == 32'(RC)));

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(ps_dq_oe && !ps_oe_n));

  a_r6_we_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_we_n |-> ps_dq_oe);

  a_r4_we_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_we_n) |-> (wl_cnt >= 32'(WP)));

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps_ce_n) |-> (hi_cnt >= 32'(CSH)));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind psram_async_ctrl psram_ctrl_chk #(
  .CLK_PS     (CLK_PS),
  .DATA_W     (DATA_W),
  .T_PWRUP_NS (T_PWRUP_NS),
  .T_RC_NS    (T_RC_NS),
  .T_AA_NS    (T_AA_NS),
  .T_WP_NS    (T_WP_NS),
  .T_CSH_NS   (T_CSH_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .ps_ce_n   (ps_ce_n),
  .ps_ce     (ps_ce),
  .ps_oe_n   (ps_oe_n),
  .ps_we_n   (ps_we_n),
  .ps_dq_oe  (ps_dq_oe)
);

// File: tb/tb_psram_async_ctrl.sv
module tb_psram_async_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = 10000;
  localparam int PWR   = (200000 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RC    = (70 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WPS   = (55 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WPL   = (70 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RUNC  = (1200 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WREC  = (RC - 1 - WPS) > 1 ? (RC - 1 - WPS) : 1;
  localparam int WCS   = 1 + WPS + WREC;
  localparam int NCH   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        ps_ce_n, ps_ce, ps_oe_n, ps_we_n, ps_dq_oe;
  logic [1:0]  ps_bsel_n;
  logic [22:0] ps_addr;
  logic [15:0] ps_dq_out, ps_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ps_ce_n(ps_ce_n), .ps_ce(ps_ce), .ps_oe_n(ps_oe_n), .ps_we_n(ps_we_n),
    .ps_bsel_n(ps_bsel_n), .ps_addr(ps_addr), .ps_dq_out(ps_dq_out),
    .ps_dq_oe(ps_dq_oe), .ps_dq_in(ps_dq_in)
  );

  int compared = 0, mismatched = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model and pin monitor ----------------
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic        sel;
  int cs_lo = 0, cs_hi = 0, last_cs = 0, cs_runs = 0, min_gap = 1000;
  int wl = 0, we_cnt = 0;
  int we_hist [128];
  int viol_r2 = 0, viol_r6 = 0;

  assign sel = !ps_ce_n && ps_ce;
  assign ps_dq_in = {(sel && !ps_oe_n && !ps_bsel_n[1]) ? mem[ps_addr[7:0]][15:8] : 8'hA5,
                     (sel && !ps_oe_n && !ps_bsel_n[0]) ? mem[ps_addr[7:0]][7:0]  : 8'hA5};

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};
    end else begin
      if (sel) begin
        if (cs_lo == 0) begin
          if (cs_runs > 0 && cs_hi < min_gap) min_gap = cs_hi;
          cs_runs++;
        end
        cs_lo++;
        cs_hi = 0;
      end else begin
        if (cs_lo != 0) last_cs = cs_lo;
        cs_lo = 0;
        cs_hi++;
      end
      if (!ps_we_n) wl++;
      else if (wl != 0) begin
        if (we_cnt < 128) we_hist[we_cnt] = wl;
        we_cnt++;
        wl = 0;
      end
      if (!sel && (!ps_we_n || !ps_oe_n || ps_dq_oe)) viol_r2++;
      if ((ps_dq_oe && !ps_oe_n) || (!ps_we_n && !ps_dq_oe)) viol_r6++;
      if (sel && !ps_we_n) begin
        if (!ps_bsel_n[0]) mem[ps_addr[7:0]][7:0]  = ps_dq_out[7:0];
        if (!ps_bsel_n[1]) mem[ps_addr[7:0]][15:8] = ps_dq_out[15:8];
      end
    end
  end

  // ---------------- request tasks ----------------
  task automatic issue(input bit wr, input logic [22:0] a, input logic [15:0] d, input logic [1:0] be);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [22:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, d, be);
    if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
    while (sel) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [22:0] a, input logic [1:0] be, output logic [15:0] q);
    issue(1'b0, a, 16'h0, be);
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    @(negedge clk);
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] be);
    return v & {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] q, q0;
    int n, s, w, we_base, runs_base, bad;
    logic [22:0] a;
    logic [15:0] d;

    for (int i = 0; i < 256; i++) shadow[i] = {i[7:0], ~i[7:0]};

    repeat (3) @(negedge clk);
    // R2: reset state
    chk(ps_ce_n == 1'b1 && ps_ce == 1'b0, "R2 reset deselect", {ps_ce_n, ps_ce}, 2'b10);
    chk(rsp_valid == 1'b0 && ps_dq_oe == 1'b0, "R2 reset quiet", {rsp_valid, ps_dq_oe}, 0);
    chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);

    // R1: power-up window
    rst_n = 1'b1;
    n = 0; bad = 0;
    do begin
      @(negedge clk);
      n++;
      if (sel) bad++;
    end while (!req_ready && n < PWR + 10);
    chk(n == PWR, "R1 power-up cycles", n, PWR);
    chk(bad == 0, "R1 deselected during power-up", bad, 0);

    // R5/R4: isolated write
    do_write(23'h12_3400, 16'hBEEF, 2'b11);
    chk(last_cs == WCS, "R5 write select length", last_cs, WCS);
    chk(we_hist[0] == WPS, "R4 write pulse width", we_hist[0], WPS);

    // R10: ready low during a read access
    req_write = 1'b0; req_addr = 23'h12_3400; req_be = 2'b11; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0 && !ps_oe_n, "R10 ready low mid-read", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 16'hBEEF, "R3 read word", rsp_rdata, 16'hBEEF);
    @(negedge clk);
    chk(last_cs == RC, "R3 read select length", last_cs, RC);

    // R3/R4: sweep of write lanes x read lanes x addresses
    for (int ai = 0; ai < 4; ai++) begin
      for (int bw = 0; bw < 4; bw++) begin
        for (int br = 0; br < 4; br++) begin
          a = 23'h5A_0010 + 23'(ai);
          d = 16'((ai * 16 + bw * 4 + br) * 16'h0F1 + 16'h3C5A);
          do_write(a, d, 2'(bw));
          do_read(a, 2'(br), q);
          chk(q == lanes(shadow[a[7:0]], 2'(br)), "R4 lane write/R3 lane read",
              q, lanes(shadow[a[7:0]], 2'(br)));
          chk(last_cs == RC, "R3 read select length", last_cs, RC);
        end
      end
    end

    // R7/R9: chained writes in one select run
    we_base = we_cnt;
    runs_base = cs_runs;
    for (int i = 0; i < NCH; i++) begin
      req_write = 1'b1; req_addr = 23'h00_0080 + 23'(i);
      req_wdata = 16'hC000 + 16'(i * 16'h0103); req_be = 2'b11; req_valid = 1'b1;
      shadow[8'h80 + i] = req_wdata;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (sel) @(negedge clk);
    @(negedge clk);
    chk(cs_runs - runs_base == 1, "R9 single select run", cs_runs - runs_base, 1);
    s = 0;
    for (int i = 0; i < NCH; i++) begin
      w = (s + 1 + WPS > RUNC) ? WPL : WPS;
      chk(we_hist[we_base + i] == w, "R7 chained pulse width", we_hist[we_base + i], w);
      s += 2 + w;
    end
    for (int i = 0; i < NCH; i += 7) begin
      do_read(23'h00_0080 + 23'(i), 2'b11, q);
      chk(q == shadow[8'h80 + i], "R9 chained data", q, shadow[8'h80 + i]);
    end

    // R11: response back-pressure
    rsp_ready = 1'b0;
    issue(1'b0, 23'h00_0085, 16'h0, 2'b10);
    while (!rsp_valid) @(negedge clk);
    q0 = rsp_rdata;
    chk(q0 == lanes(shadow[8'h85], 2'b10), "R3 upper lane only", q0, lanes(shadow[8'h85], 2'b10));
    req_write = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == q0 && !req_ready, "R11 hold under back-pressure",
          {rsp_valid, req_ready}, 2'b10);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 released", rsp_valid, 0);

    // R2/R6/R8 monitor results
    repeat (3) @(negedge clk);
    chk(viol_r2 == 0, "R2 quiet while deselected", viol_r2, 0);
    chk(viol_r6 == 0, "R6 bus enable window", viol_r6, 0);
    chk(min_gap >= 1, "R8 deselect gap", min_gap, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule